// File: doc/BRIEF.md
# Event Counter Bank with Overflow Status and Interrupt

This block holds a set of general counters and a set of fixed counters. Each general counter has its own selector word. That word holds an enable bit, two privilege filters, an interrupt enable and a threshold. The threshold decides whether the counter adds the number of events reported in a cycle, or adds one only when that number is large enough. The fixed counters count single-bit event pulses. They share one control word, in which each fixed counter owns a 4-bit field.

A counter counts only when both of these are set:
- its own enable, which is the selector enable bit for a general counter or the privilege bits of its field for a fixed counter;
- its bit in a shared enable word.

When a counter wraps past its top bit, it sets a sticky bit in a shared status word. Software clears that bit by writing a one to the same bit position of a separate clear word. If the counter's interrupt enable is set, the wrap also produces a one-cycle interrupt pulse.

Software works through a single-cycle register bus. Writes take effect on the clock edge and reads are combinational. Writing a counter while it is running replaces its value at once. Software usually presets a counter to 2^CW − K so that it overflows on exactly the K-th event.

Top module: `evctr_bank`

## Requirements
- R1: After reset every counter, selector word, the fixed control word, the shared enable word and the status word read zero, and `irq` is low.
- R2: Register map (byte-free word addresses): general counter n at 0x00+n, selector n at 0x10+n, fixed counter i at 0x20+i, fixed control 0x30, shared enable 0x31, status 0x32, clear 0x33. Counter writes keep the low CW bits. Selector words keep 16 bits, fixed control keeps 4·NFIX bits, and the shared enable keeps only implemented bits. Everything else reads back as written.
- R3: In the shared enable and status words, general counter n owns bit n and fixed counter i owns bit 32+i. A counter does not move unless its local enable (selector bit 0 for general counters) and its shared enable bit are both 1.
- R4: `priv_user`=1 means user level and 0 means supervisor level. A general counter counts at supervisor level only with selector bit 1 set, and at user level only with selector bit 2 set. For a fixed counter the same roles belong to field bit 0 (supervisor) and field bit 1 (user).
- R5: Selector bits 15:8 form a threshold. When the threshold is zero, the counter adds the cycle's event count (EVW-bit input). When it is non-zero, the counter adds 1 in cycles whose event count is at least the threshold, and adds nothing otherwise.
- R6: A counting fixed counter adds one in each cycle in which its event pulse is high. Fixed counter i uses control bits 4i+3..4i.
- R7: A carry out of bit CW-1 wraps the counter modulo 2^CW and sets its status bit at the same edge. The bit stays set until it is cleared. A counter preset to 2^CW − K reaches zero on the K-th counted event, and its status is visible right after that edge.
- R8: Writing the clear word clears exactly the status bits written as 1; bits written as 0 are untouched. If a new overflow lands in the same cycle as its clear, the bit stays set.
- R9: Overflow raises `irq` for exactly one cycle, starting just after the wrapping edge, if the counter's interrupt enable is set (selector bit 3, fixed field bit 3); without it only the status changes. Several overflows in one cycle set all their status bits.
- R10: A bus write to a counter that is counting replaces its value at that edge; that cycle's increment is discarded and counting resumes from the written value.
- R11: The status word cannot be written through its own address; such writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_gen | input | NGEN*EVW | Per-cycle event count for each general counter, counter n in bits n*EVW +: EVW |
| ev_fix | input | NFIX | Per-cycle event pulse for each fixed counter |
| priv_user | input | 1 | 1 = user level, 0 = supervisor level |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data for `bus_addr` |
| irq | output | 1 | One-cycle overflow interrupt pulse |

## Verification
A corrupted counter, selector or enable bit shows up on the next read of that counter: the value is off by the events the filter should have admitted or rejected. A stuck or lost status bit is visible on the status read in the cycle right after the wrap. An interrupt fault shows up in that same cycle as a missing, extra or stretched pulse on `irq`. Threshold comparison errors stay hidden unless the event count sits right at, just below or above the threshold, so those exact values are applied.

// File: rtl/evctr_bank.sv
`timescale 1ns/1ps
module evctr_bank #(
  parameter int NGEN     = 4,
  parameter int NFIX     = 3,
  parameter int CW       = 48,
  parameter int EVW      = 4,
  parameter int FIX_BASE = 32,
  parameter int DW       = 64,
  parameter int AW       = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NGEN*EVW-1:0]  ev_gen,
  input  logic [NFIX-1:0]      ev_fix,
  input  logic                 priv_user,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic                 irq
);
  localparam logic [AW-1:0] A_GCNT  = AW'('h00);
  localparam logic [AW-1:0] A_GSEL  = AW'('h10);
  localparam logic [AW-1:0] A_FCNT  = AW'('h20);
  localparam logic [AW-1:0] A_FCTL  = AW'('h30);
  localparam logic [AW-1:0] A_GEN   = AW'('h31);
  localparam logic [AW-1:0] A_GSTAT = AW'('h32);
  localparam logic [AW-1:0] A_GCLR  = AW'('h33);
  localparam int FW = 4 * NFIX;
  localparam logic [DW-1:0] GMASK =
    ((DW'(1) << NGEN) - DW'(1)) | (((DW'(1) << NFIX) - DW'(1)) << FIX_BASE);

  logic [NGEN-1:0][CW-1:0] gcnt, gnext;
  logic [NGEN-1:0][15:0]   gsel;
  logic [NFIX-1:0][CW-1:0] fcnt, fnext;
  logic [FW-1:0]           fctl;
  logic [DW-1:0]           genable, gstat, ovf, ovf_int, clr;
  logic [NGEN-1:0]         gwrap, gwr, gie;
  logic [NFIX-1:0]         fwrap, fwr, fie;

  for (genvar g = 0; g < NGEN; g++) begin : g_gen
    logic [EVW-1:0] ev;
    logic [7:0]     cm;
    logic           act;
    logic [CW-1:0]  step;
    logic [CW:0]    sum;
    assign ev   = ev_gen[g*EVW +: EVW];
    assign cm   = gsel[g][15:8];
    assign act  = gsel[g][0] & genable[g] & (priv_user ? gsel[g][2] : gsel[g][1]);
    assign step = !act ? '0 : (cm == 8'd0) ? CW'(ev) : CW'(32'(ev) >= 32'(cm));
    assign sum  = {1'b0, gcnt[g]} + {1'b0, step};
    assign gwr[g]   = bus_wr && (bus_addr == A_GCNT + AW'(g));
    assign gwrap[g] = sum[CW] & ~gwr[g];
    assign gnext[g] = sum[CW-1:0];
    assign gie[g]   = gsel[g][3];
  end

  for (genvar f = 0; f < NFIX; f++) begin : g_fix
    logic [3:0]  fld;
    logic        act;
    logic [CW:0] sum;
    assign fld = fctl[4*f +: 4];
    assign act = ev_fix[f] & genable[FIX_BASE+f] & (priv_user ? fld[1] : fld[0]);
    assign sum = {1'b0, fcnt[f]} + (CW+1)'(act);
    assign fwr[f]   = bus_wr && (bus_addr == A_FCNT + AW'(f));
    assign fwrap[f] = sum[CW] & ~fwr[f];
    assign fnext[f] = sum[CW-1:0];
    assign fie[f]   = fld[3];
  end

  assign ovf     = DW'(gwrap) | (DW'(fwrap) << FIX_BASE);
  assign ovf_int = DW'(gwrap & gie) | (DW'(fwrap & fie) << FIX_BASE);
  assign clr     = (bus_wr && bus_addr == A_GCLR) ? (bus_wdata & GMASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcnt    <= '0;
      gsel    <= '0;
      fcnt    <= '0;
      fctl    <= '0;
      genable <= '0;
      gstat   <= '0;
      irq     <= 1'b0;
    end else begin
      for (int g = 0; g < NGEN; g++) begin
        gcnt[g] <= gwr[g] ? bus_wdata[CW-1:0] : gnext[g];
        if (bus_wr && bus_addr == A_GSEL + AW'(g)) gsel[g] <= bus_wdata[15:0];
      end
      for (int f = 0; f < NFIX; f++)
        fcnt[f] <= fwr[f] ? bus_wdata[CW-1:0] : fnext[f];
      if (bus_wr && bus_addr == A_FCTL) fctl <= bus_wdata[FW-1:0];
      if (bus_wr && bus_addr == A_GEN)  genable <= bus_wdata & GMASK;
      gstat <= (gstat & ~clr) | ovf;
      irq   <= |ovf_int;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int g = 0; g < NGEN; g++) begin
      if (bus_addr == A_GCNT + AW'(g)) bus_rdata = DW'(gcnt[g]);
      if (bus_addr == A_GSEL + AW'(g)) bus_rdata = DW'(gsel[g]);
    end
    for (int f = 0; f < NFIX; f++)
      if (bus_addr == A_FCNT + AW'(f)) bus_rdata = DW'(fcnt[f]);
    if (bus_addr == A_FCTL)  bus_rdata = DW'(fctl);
    if (bus_addr == A_GEN)   bus_rdata = genable;
    if (bus_addr == A_GSTAT) bus_rdata = gstat;
  end
endmodule

// File: rtl/evctr_bank_chk.sv
`timescale 1ns/1ps
module evctr_bank_chk #(
  parameter int NGEN = 4,
  parameter int NFIX = 3,
  parameter int CW   = 48,
  parameter int DW   = 64,
  parameter int AW   = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_wr,
  input logic [AW-1:0]           bus_addr,
  input logic [DW-1:0]           bus_wdata,
  input logic                    irq,
  input logic [DW-1:0]           genable,
  input logic [DW-1:0]           gstat,
  input logic [NGEN-1:0][CW-1:0] gcnt,
  input logic [NFIX-1:0][CW-1:0] fcnt
);
  localparam logic [AW-1:0] A_CLR = AW'('h33);
  logic clr_wr;
  assign clr_wr = bus_wr && (bus_addr == A_CLR);

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (!irq && gstat == '0));

  assert_sticky_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> (($past(gstat) & ~gstat) == '0));

  assert_gated_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (genable == '0 && !bus_wr) |=> ($stable(gcnt) && $stable(fcnt)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && genable == '0) |=> ((gstat & $past(bus_wdata)) == '0));

  assert_irq_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (gstat != '0));
endmodule

bind evctr_bank evctr_bank_chk #(
  .NGEN(NGEN), .NFIX(NFIX), .CW(CW), .DW(DW), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(irq), .genable(genable), .gstat(gstat),
  .gcnt(gcnt), .fcnt(fcnt)
);

// File: tb/test_evctr_bank.sv
`timescale 1ns/1ps
module test_evctr_bank;
  localparam logic [7:0] GCNT = 8'h00, GSEL = 8'h10, FCNT = 8'h20, FCTL = 8'h30;
  localparam logic [7:0] GEN = 8'h31, GSTAT = 8'h32, GCLR = 8'h33;
  localparam logic [63:0] ALL1 = 64'h0000_FFFF_FFFF_FFFF;
  // {threshold[7:0], event count[3:0], expected increment[3:0]}
  localparam logic [15:0] VEC [10] = '{16'h0000, 16'h0011, 16'h0077, 16'h00FF,
    16'h0210, 16'h0221, 16'h0291, 16'h0FE0, 16'h0FF1, 16'hFFF0};

  logic clk = 0, rst_n = 0, priv_user = 0, bus_wr = 0, irq;
  logic [15:0] ev_gen = '0;
  logic [2:0]  ev_fix = '0;
  logic [7:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0, bus_rdata;
  int nchk = 0, nerr = 0;

  always #5 clk = ~clk;

  evctr_bank i_evctr_bank (.clk(clk), .rst_n(rst_n), .ev_gen(ev_gen), .ev_fix(ev_fix),
    .priv_user(priv_user), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [63:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic pulse(input logic [15:0] g, input logic [2:0] f);
    ev_gen = g; ev_fix = f;
    @(negedge clk);
    ev_gen = '0; ev_fix = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rdchk("R1 counter", GCNT, 0);
    rdchk("R1 selector", GSEL, 0);
    rdchk("R1 fixed ctl", FCTL, 0);
    rdchk("R1 enable", GEN, 0);
    rdchk("R1 status", GSTAT, 0);
    chk("R1 irq", irq, 0);

    // R2 map and readback widths
    wr(GSEL + 1, 64'hFFFF_AB0F);
    rdchk("R2 selector", GSEL + 1, 64'hAB0F);
    wr(GCNT + 1, 64'hFFFF_0123_4567_89AB);
    rdchk("R2 counter width", GCNT + 1, 64'h0000_0123_4567_89AB);
    wr(FCTL, 64'hFFFF_F321);
    rdchk("R2 fixed ctl", FCTL, 64'h321);
    wr(GEN, '1);
    rdchk("R2 enable bits", GEN, 64'h0000_0007_0000_000F);
    wr(GEN, 0); wr(GSEL + 1, 0); wr(GCNT + 1, 0); wr(FCTL, 0);

    // R5 threshold table
    wr(GEN, 1);
    for (int i = 0; i < 10; i++) begin
      wr(GCNT, 0);
      wr(GSEL, {48'd0, VEC[i][15:8], 8'h07});
      pulse({12'd0, VEC[i][7:4]}, 0);
      rdchk($sformatf("R5 vector %0d", i), GCNT, {60'd0, VEC[i][3:0]});
    end

    // R3 dual enable and bit placement
    wr(GEN, 0); wr(GCNT, 0); wr(GSEL, 7);
    pulse(16'h0004, 0);
    rdchk("R3 shared enable off", GCNT, 0);
    wr(GEN, 1); wr(GSEL, 6);
    pulse(16'h0004, 0);
    rdchk("R3 local enable off", GCNT, 0);
    wr(GSEL, 7); wr(GSEL + 2, 7); wr(GEN, 4);
    pulse(16'h0101, 0);
    rdchk("R3 bit 2 counts counter 2", GCNT + 2, 1);
    rdchk("R3 counter 0 gated", GCNT, 0);

    // R4 privilege filter
    wr(GEN, 1); wr(GSEL, 5); priv_user = 0;
    pulse(16'h0003, 0);
    rdchk("R4 user-only at supervisor", GCNT, 0);
    priv_user = 1;
    pulse(16'h0003, 0);
    rdchk("R4 user-only at user", GCNT, 3);
    wr(GSEL, 3);
    pulse(16'h0003, 0);
    rdchk("R4 supervisor-only at user", GCNT, 3);
    priv_user = 0;
    pulse(16'h0003, 0);
    rdchk("R4 supervisor-only at supervisor", GCNT, 6);

    // R6 fixed counters
    wr(GEN, 64'h2_0000_0000); wr(FCTL, 64'h030);
    for (int k = 0; k < 3; k++) pulse(0, 3'b011);
    rdchk("R6 fixed 1 count", FCNT + 1, 3);
    rdchk("R6 fixed 0 no field", FCNT, 0);
    wr(GEN, 0);
    pulse(0, 3'b010);
    rdchk("R6 R3 fixed gated", FCNT + 1, 3);

    // R7 preset and wrap
    wr(GCLR, '1); wr(GSEL, 7); wr(FCTL, 0); wr(GCNT, ALL1 - 2); wr(GEN, 1);
    pulse(1, 0); pulse(1, 0);
    rdchk("R7 no early status", GSTAT, 0);
    pulse(1, 0);
    chk("R9 no irq without enable", irq, 0);
    rdchk("R7 wrapped to zero", GCNT, 0);
    rdchk("R7 status set", GSTAT, 1);
    repeat (3) @(negedge clk);
    rdchk("R7 status sticky", GSTAT, 1);
    wr(GCNT, ALL1 - 1);
    pulse(5, 0);
    rdchk("R7 multi-event wrap", GCNT, 3);

    // R8 clear
    wr(GCLR, 0);
    rdchk("R8 zero write keeps", GSTAT, 1);
    wr(GCLR, 1);
    rdchk("R8 one write clears", GSTAT, 0);
    wr(GCNT, ALL1);
    ev_gen = 1; bus_wr = 1; bus_addr = GCLR; bus_wdata = 1;
    @(negedge clk);
    ev_gen = 0; bus_wr = 0;
    rdchk("R8 new overflow beats clear", GSTAT, 1);

    // R9 interrupt pulse
    wr(GCLR, '1); wr(GEN, 0); wr(GSEL, 0); wr(FCTL, 64'h0B0);
    wr(FCNT + 1, ALL1); wr(GEN, 64'h2_0000_0000);
    pulse(0, 3'b010);
    chk("R9 fixed irq", irq, 1);
    rdchk("R9 fixed wrapped", FCNT + 1, 0);
    rdchk("R9 fixed status bit 33", GSTAT, 64'h2_0000_0000);
    @(negedge clk);
    chk("R9 irq one cycle", irq, 0);
    wr(GCLR, '1); wr(FCTL, 0); wr(GSEL, 64'hF); wr(GSEL + 1, 64'hF);
    wr(GCNT, ALL1); wr(GCNT + 1, ALL1); wr(GEN, 3);
    pulse(16'h0011, 0);
    chk("R9 simultaneous irq", irq, 1);
    rdchk("R9 simultaneous status", GSTAT, 3);
    @(negedge clk);
    chk("R9 simultaneous pulse ends", irq, 0);

    // R10 write while running
    wr(GEN, 0); wr(GCLR, '1); wr(GSEL, 7); wr(GSEL + 1, 0); wr(GCNT, 0); wr(GEN, 1);
    ev_gen = 1;
    @(negedge clk); @(negedge clk);
    rdchk("R10 running", GCNT, 2);
    wr(GCNT, 100);
    rdchk("R10 written value", GCNT, 100);
    @(negedge clk);
    rdchk("R10 resumes", GCNT, 101);
    ev_gen = 0;

    // R11 status not writable
    wr(GSTAT, 64'hF);
    rdchk("R11 status write ignored", GSTAT, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule